// File: doc/BRIEF.md
# UART Receive FIFO with Trigger Level and Character Timeout

This block holds the bytes a serial receiver has assembled until the host reads them. In FIFO mode it stores up to 16 bytes in arrival order. With FIFO mode off it behaves as a single holding register. A FIFO control byte written by the host selects the mode, the receive trigger level and a DMA-mode flag. The same byte can also carry one-shot clear commands for the receive and transmit FIFOs. The trigger level, fill count, data-ready flag and a character-timeout flag go to the UART's interrupt logic.

The character timeout is measured in bit periods, counted on an external baud strobe. The character time comes from the line-control settings: data bits, plus stop bits, plus one bit when parity is on. Four character times with no receive activity and no host read, while bytes are waiting, raise the timeout flag.

The byte input is a stream with a valid strobe and no ready. The receiver cannot be held back, so a byte that finds no room is dropped and reported as an overrun. The host read strobe pops one entry. Its data is valid in the same cycle, before the pop takes effect.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset the FIFO is empty, data_ready, break_ind, timeout_pend and overrun are 0, FIFO mode is off, dma_mode is 0 and trig_level is 1.
- R2: A control write stores only bits 7, 6, 3 and 0. Bit 0 enables FIFO mode, bit 3 is reported on dma_mode, and bits 7:6 select trig_level: 00 gives 1, 01 gives 4, 10 gives 8, 11 gives 14.
- R3: In FIFO mode up to 16 bytes are returned in arrival order across index wrap, and count tracks the fill level.
- R4: A byte arriving with no room (16 entries in FIFO mode, 1 with FIFO mode off) and no pop in the same cycle is discarded. overrun is high for the one cycle that follows.
- R5: rd_data shows the oldest byte and reads 0 when empty. data_ready is 1 exactly while the count is non-zero.
- R6: A control write with bit 1 set empties the receive FIFO and cancels the timeout and its pending flag. Bit 2 produces a one-cycle tx_flush pulse. Neither bit is stored.
- R7: A control write that changes bit 0 flushes both FIFOs as if bits 1 and 2 were set.
- R8: With FIFO mode off, only one byte is held.
- R9: One character time in bit ticks is (lcr[1:0]+5) + (lcr[2] ? 2 : 1) + lcr[3]. timeout_pend rises after exactly 4 character times of baud ticks with bytes waiting.
- R10: Each accepted byte restarts the timeout, and so does a read that leaves bytes behind. Any read clears timeout_pend.
- R11: A read that empties the FIFO stops the timeout, so timeout_pend stays 0 while the FIFO is empty.
- R12: A byte received with rx_break set raises break_ind. break_ind clears only when a read empties the FIFO or the receive FIFO is flushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle strobe per bit period |
| lcr | input | 4 | Line control: [1:0] data bits-5, [2] two stop bits, [3] parity on |
| fcr_wr | input | 1 | Control byte write strobe |
| fcr_wdata | input | 8 | Control byte |
| rx_valid | input | 1 | Received byte valid (no back-pressure) |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Break condition seen with this byte |
| rd_en | input | 1 | Host read, pops one entry |
| rd_data | output | 8 | Oldest byte, 0 when empty |
| count | output | 5 | Fill level |
| data_ready | output | 1 | FIFO non-empty |
| break_ind | output | 1 | Break indicator |
| trig_level | output | 5 | Receive trigger level in bytes |
| timeout_pend | output | 1 | Character timeout pending |
| overrun | output | 1 | Byte dropped last cycle |
| fifo_en | output | 1 | FIFO mode on |
| dma_mode | output | 1 | Stored DMA-mode flag |
| tx_flush | output | 1 | One-cycle transmit FIFO clear command |

## Verification
The bench builds the block with its defaults: a depth of 16 and a timeout of four character times. With these values the bench can completely fill the FIFO after an offset, which crosses the index wrap, and can then drop a byte. The short window lets the bench count baud ticks up to the exact edge of expiry for two frame sizes, 9 and 8 bits. It also covers all four trigger codes and the switch into and out of single-register mode.

// File: rtl/uart_rx_fifo_pkg.sv
package uart_rx_fifo_pkg;

  localparam logic [7:0] CTRL_KEEP_MASK = 8'hC9;

  function automatic logic [4:0] level_of(input logic [1:0] code);
    case (code)
      2'b00:   level_of = 5'd1;
      2'b01:   level_of = 5'd4;
      2'b10:   level_of = 5'd8;
      default: level_of = 5'd14;
    endcase
  endfunction

  function automatic logic [3:0] frame_bits(input logic [3:0] lc);
    frame_bits = 4'd5 + {2'b00, lc[1:0]} + (lc[2] ? 4'd2 : 4'd1) + {3'b000, lc[3]};
  endfunction

endpackage

// File: rtl/rxf_ctrl_reg.sv
module rxf_ctrl_reg
  import uart_rx_fifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] ctrl_q,
  output logic       flush_rx,
  output logic       flush_tx_pulse
);
  logic apply, toggled, flush_tx;

  assign apply    = wr && (wdata != ctrl_q);
  assign toggled  = wdata[0] ^ ctrl_q[0];
  assign flush_rx = apply && (wdata[1] || toggled);
  assign flush_tx = apply && (wdata[2] || toggled);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q         <= '0;
      flush_tx_pulse <= 1'b0;
    end else begin
      flush_tx_pulse <= flush_tx;
      if (apply) ctrl_q <= wdata & CTRL_KEEP_MASK;
    end
  end
endmodule

// File: rtl/rxf_ring.sv
module rxf_ring #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          single,
  input  logic          push_valid,
  input  logic [DW-1:0] push_data,
  input  logic          push_brk,
  input  logic          pop,
  output logic [DW-1:0] head_data,
  output logic [CW-1:0] count,
  output logic          brk,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          drop
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          full;

  assign full    = single ? (count != '0) : (count == CW'(DEPTH));
  assign pop_ok  = pop && (count != '0) && !flush;
  assign push_ok = push_valid && !flush && (!full || pop_ok);
  assign drop    = push_valid && !flush && !push_ok;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    nxt = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (push_ok && (wptr == AW'(i))) mem[i] <= push_data;
    end
  end

  assign head_data = (count != '0) ? mem[rptr] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      brk   <= 1'b0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      brk   <= 1'b0;
    end else begin
      if (push_ok) wptr <= nxt(wptr);
      if (pop_ok)  rptr <= nxt(rptr);
      if (push_ok && !pop_ok)      count <= count + 1'b1;
      else if (pop_ok && !push_ok) count <= count - 1'b1;
      if (push_ok && push_brk)                        brk <= 1'b1;
      else if (pop_ok && !push_ok && count == CW'(1)) brk <= 1'b0;
    end
  end
endmodule

// File: rtl/rxf_char_timer.sv
module rxf_char_timer
  import uart_rx_fifo_pkg::*;
#(
  parameter int TMO_CHARS = 4,
  localparam int LIM_MAX  = 11 * TMO_CHARS,
  localparam int TW       = $clog2(LIM_MAX + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] lcr,
  input  logic       tick,
  input  logic       restart,
  input  logic       cancel,
  input  logic       clear_pend,
  input  logic       nonempty,
  output logic       pend
);
  logic [TW-1:0] limit, cnt;
  logic          armed, expire;

  assign limit  = TW'(frame_bits(lcr)) * TW'(TMO_CHARS);
  assign expire = armed && tick && !restart && !cancel && (cnt == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
      pend  <= 1'b0;
    end else begin
      if (cancel) begin
        armed <= 1'b0;
        cnt   <= '0;
      end else if (restart) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (expire) begin
        armed <= 1'b0;
        cnt   <= '0;
      end else if (armed && tick) begin
        cnt <= cnt + 1'b1;
      end
      if (cancel || clear_pend)   pend <= 1'b0;
      else if (expire && nonempty) pend <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_fifo_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int TMO_CHARS = 4,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic [3:0]    lcr,
  input  logic          fcr_wr,
  input  logic [7:0]    fcr_wdata,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_break,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  output logic [CW-1:0] count,
  output logic          data_ready,
  output logic          break_ind,
  output logic [4:0]    trig_level,
  output logic          timeout_pend,
  output logic          overrun,
  output logic          fifo_en,
  output logic          dma_mode,
  output logic          tx_flush
);
  logic [7:0] ctrl_q;
  logic       flush_rx, push_ok, pop_ok, drop;
  logic       t_restart, t_cancel;

  rxf_ctrl_reg u_ctrl (
    .clk, .rst_n, .wr(fcr_wr), .wdata(fcr_wdata),
    .ctrl_q, .flush_rx, .flush_tx_pulse(tx_flush)
  );

  assign fifo_en    = ctrl_q[0];
  assign dma_mode   = ctrl_q[3];
  assign trig_level = level_of(ctrl_q[7:6]);

  rxf_ring #(.DW(8), .DEPTH(DEPTH)) u_ring (
    .clk, .rst_n, .flush(flush_rx), .single(!fifo_en),
    .push_valid(rx_valid), .push_data(rx_data), .push_brk(rx_break),
    .pop(rd_en), .head_data(rd_data), .count, .brk(break_ind),
    .push_ok, .pop_ok, .drop
  );

  assign data_ready = (count != '0);

  assign t_restart = fifo_en && (push_ok || (pop_ok && count > CW'(1)));
  assign t_cancel  = flush_rx || !fifo_en || (pop_ok && !push_ok && count == CW'(1));

  rxf_char_timer #(.TMO_CHARS(TMO_CHARS)) u_tmo (
    .clk, .rst_n, .lcr, .tick(baud_tick),
    .restart(t_restart), .cancel(t_cancel), .clear_pend(rd_en),
    .nonempty(data_ready), .pend(timeout_pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) overrun <= 1'b0;
    else        overrun <= drop;
  end
endmodule

// File: rtl/uart_rx_fifo_sva.sv
module uart_rx_fifo_sva #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fcr_wr,
  input logic [7:0]    fcr_wdata,
  input logic          rx_valid,
  input logic          rd_en,
  input logic [CW-1:0] count,
  input logic [4:0]    trig_level,
  input logic          timeout_pend,
  input logic          overrun,
  input logic          fifo_en
);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  assert_drop_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && fifo_en && count == CW'(DEPTH) && !rd_en && !fcr_wr) |=> overrun);

  assert_rx_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fcr_wr && fcr_wdata[1]) |=> (count == '0 && !timeout_pend));

  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !timeout_pend);

  assert_level_codes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_level == 5'd1 || trig_level == 5'd4 || trig_level == 5'd8 || trig_level == 5'd14));

  assert_single_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> (count <= CW'(1)));

  assert_empty_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !timeout_pend);
endmodule

bind uart_rx_fifo uart_rx_fifo_sva #(.DEPTH(DEPTH)) u_sva (
  .clk(clk), .rst_n(rst_n), .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata),
  .rx_valid(rx_valid), .rd_en(rd_en), .count(count), .trig_level(trig_level),
  .timeout_pend(timeout_pend), .overrun(overrun), .fifo_en(fifo_en)
);

// File: tb/tb_uart_rx_fifo.sv
module tb_uart_rx_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic [3:0] lcr = 4'b0011;
  logic       fcr_wr = 1'b0;
  logic [7:0] fcr_wdata = '0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_break = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic [4:0] count;
  logic       data_ready, break_ind, timeout_pend, overrun, fifo_en, dma_mode, tx_flush;
  logic [4:0] trig_level;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_rx_fifo dut (
    .clk, .rst_n, .baud_tick, .lcr, .fcr_wr, .fcr_wdata, .rx_valid, .rx_data,
    .rx_break, .rd_en, .rd_data, .count, .data_ready, .break_ind, .trig_level,
    .timeout_pend, .overrun, .fifo_en, .dma_mode, .tx_flush
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b, input logic brk = 1'b0);
    @(negedge clk); rx_valid = 1'b1; rx_data = b; rx_break = brk;
    @(negedge clk); rx_valid = 1'b0; rx_break = 1'b0;
  endtask

  task automatic pop(output logic [7:0] b);
    @(negedge clk); b = rd_data; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk); fcr_wr = 1'b1; fcr_wdata = v;
    @(negedge clk); fcr_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); baud_tick = 1'b1;
      @(negedge clk); baud_tick = 1'b0;
    end
  endtask

  task automatic t_reset();
    check("R1 count", count, 0);
    check("R1 data_ready", data_ready, 0);
    check("R1 timeout", timeout_pend, 0);
    check("R1 fifo_en", fifo_en, 0);
    check("R1 trig", trig_level, 1);
    check("R1 break/overrun/dma", {break_ind, overrun, dma_mode}, 0);
  endtask

  task automatic t_decode();
    wr_ctrl(8'h41);
    check("R2 enable", fifo_en, 1);
    check("R2 trig 01", trig_level, 4);
    check("R7 toggle tx_flush", tx_flush, 1);
    wr_ctrl(8'h81);
    check("R2 trig 10", trig_level, 8);
    check("R6 no tx_flush", tx_flush, 0);
    wr_ctrl(8'hC9);
    check("R2 trig 11", trig_level, 14);
    check("R2 dma", dma_mode, 1);
    wr_ctrl(8'hC1);
    check("R2 dma off", dma_mode, 0);
  endtask

  task automatic t_order_wrap();
    logic [7:0] b;
    for (int i = 0; i < 5; i++) push(8'h80 + 8'(i));
    for (int i = 0; i < 5; i++) begin
      pop(b); check("R3 order", b, 8'h80 + i);
    end
    for (int i = 0; i < 16; i++) push(8'h10 + 8'(i));
    check("R3 count full", count, 16);
    push(8'hEE);
    check("R4 overrun pulse", overrun, 1);
    check("R4 count kept", count, 16);
    @(negedge clk);
    check("R4 overrun one cycle", overrun, 0);
    for (int i = 0; i < 16; i++) begin
      pop(b); check("R3 wrap order", b, 8'h10 + i);
    end
    check("R5 data_ready low", data_ready, 0);
    check("R5 empty read zero", rd_data, 0);
  endtask

  task automatic t_clear();
    push(8'h01); push(8'h02); push(8'h03);
    check("R5 data_ready high", data_ready, 1);
    wr_ctrl(8'hC3);
    check("R6 rx cleared", count, 0);
    check("R6 no tx pulse", tx_flush, 0);
    push(8'h04);
    wr_ctrl(8'hC5);
    check("R6 tx pulse", tx_flush, 1);
    check("R6 rx kept", count, 1);
  endtask

  task automatic t_toggle();
    wr_ctrl(8'h00);
    check("R7 flushed", count, 0);
    check("R7 tx pulse", tx_flush, 1);
    check("R7 fifo off", fifo_en, 0);
  endtask

  task automatic t_single();
    logic [7:0] b;
    push(8'h5A); push(8'hA5);
    check("R8 overrun", overrun, 1);
    check("R8 one held", count, 1);
    pop(b);
    check("R8 first kept", b, 8'h5A);
  endtask

  task automatic t_timeout();
    logic [7:0] b;
    wr_ctrl(8'h01);
    lcr = 4'b0011;
    push(8'h33);
    ticks(35);
    check("R9 before expiry 9b", timeout_pend, 0);
    ticks(1);
    check("R9 expiry 9b", timeout_pend, 1);
    pop(b);
    check("R10 read clears", timeout_pend, 0);
    lcr = 4'b1100;
    push(8'h44); push(8'h45);
    ticks(20);
    pop(b);
    ticks(31);
    check("R10 restarted by read", timeout_pend, 0);
    ticks(1);
    check("R9 expiry 8b", timeout_pend, 1);
    pop(b);
    ticks(40);
    check("R11 empty no timeout", timeout_pend, 0);
    lcr = 4'b0011;
  endtask

  task automatic t_break();
    logic [7:0] b;
    push(8'h00, 1'b1); push(8'h77);
    check("R12 break set", break_ind, 1);
    pop(b);
    check("R12 break held", break_ind, 1);
    pop(b);
    check("R12 break cleared", break_ind, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_order_wrap();
    t_clear();
    t_toggle();
    t_single();
    t_timeout();
    t_break();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule